// File: doc/BRIEF.md
# Interrupt Request Priority Arbiter

This block is the accept-and-prioritise core of a per-processor interrupt controller. It keeps three bit vectors, each with one bit per interrupt vector: requests waiting to be taken, requests currently being serviced, and the trigger kind each pending request arrived with. Delivery requests carry a vector number and a level/edge flag. A delivery sets the vector's waiting bit unless that bit is already set, in which case the delivery is dropped.

When the processor asks for an interrupt, the block finds the highest waiting vector. It grants that vector only if two conditions hold. First, the vector must be numerically above every vector in service. Second, its priority class, which is the upper four bits of the vector number, must be above the class held in the task-priority register. A granted vector moves from waiting to in-service, and its number is returned on the next cycle.

An end-of-interrupt write retires the highest in-service vector. If that vector arrived level-triggered, a remote end-of-interrupt pulse carries its number out. Software-visible readback is limited to one selectable 32-bit slice of each of the three vectors.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset the waiting, in-service and trigger vectors are all zero, `tpr_q` is 0, and `ack_done`, `ack_hit`, `reoi_valid` and `bad_vec` are 0.
- R2: An accepted delivery sets the vector's waiting bit. It also sets the vector's trigger bit to 1 when `dlv_level`=1 and clears it to 0 when `dlv_level`=0.
- R3: A delivery to a vector whose waiting bit is already set is dropped. It leaves the waiting and trigger bits unchanged.
- R4: A delivery of a vector whose upper four bits are zero (below 0x10), or of vector 0xFF, raises `bad_vec` for one cycle on the following cycle and changes no state.
- R5: Every cycle with `ack_req`=1 is followed one cycle later by `ack_done`=1. If nothing is granted, `ack_hit`=0 and `ack_vec`=0.
- R6: No grant happens when the highest in-service vector is greater than or equal to the highest waiting vector.
- R7: No grant happens when bits [7:4] of the highest waiting vector are less than or equal to bits [7:4] of `tpr_q`.
- R8: A grant always picks the highest waiting vector. It clears that vector's waiting bit, sets its in-service bit, and reports `ack_hit`=1 with the vector on `ack_vec`.
- R9: `eoi_wr` clears the highest set in-service bit. On the next cycle, if that vector's trigger bit was 1, `reoi_valid` pulses with the vector on `reoi_vec`.
- R10: `eoi_wr` with no in-service bit set changes nothing and raises no `reoi_valid`.
- R11: `tpr_wr` loads bits [7:0] of `tpr_wdata` into `tpr_q`, which shows the new value on the next cycle. Bits [31:8] are discarded.
- R12: Readback slice `rd_sel`=k carries vectors 32k..32k+31, with vector v at bit v mod 32. The `*_slice` outputs are registered and show the state one cycle after selection.
- R13: A delivery and an acknowledge in the same cycle see the delivery first, so the just-delivered vector can be granted. An acknowledge that coincides with `eoi_wr` is judged against the in-service set from before that end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dlv_valid | input | 1 | Delivery request strobe |
| dlv_vec | input | 8 | Vector number being delivered |
| dlv_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_req | input | 1 | Processor acknowledge strobe |
| ack_done | output | 1 | Acknowledge answered (one cycle after `ack_req`) |
| ack_hit | output | 1 | A vector was granted |
| ack_vec | output | 8 | Granted vector, 0 when none |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| reoi_valid | output | 1 | Remote end-of-interrupt pulse for a level vector |
| reoi_vec | output | 8 | Vector retired with remote notify |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 32 | Task-priority write data |
| tpr_q | output | 8 | Current task priority |
| bad_vec | output | 1 | Invalid-vector delivery flag |
| rd_sel | input | 3 | Readback slice index |
| pend_slice | output | 32 | Selected slice of the waiting vector |
| serv_slice | output | 32 | Selected slice of the in-service vector |
| trig_slice | output | 32 | Selected slice of the trigger vector |

## Verification
A corrupted waiting or in-service bit shows up at the very next acknowledge. The grant either names a different vector, or it turns into a miss where a hit was due, or the reverse. A wrong trigger bit stays hidden until that vector is retired. At that point the end-of-interrupt either raises a remote pulse it should not, or stays silent when it should pulse. Since that can be many cycles after the faulty delivery, the bench also reads all three vectors back through the slice ports. There, any bit error appears one cycle after the slice is selected.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // Width of the priority class field at the top of a vector number.
  localparam int CLASS_W = 4;

  // Index of each tracked vector within the readback bundle.
  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_SERV = 2'd1,
    REG_TRIG = 2'd2
  } arb_reg_e;

  localparam int NUM_REGS = 3;
endpackage

// File: rtl/irq_hi_enc.sv
// Highest-set-bit finder: combinational, last set bit in ascending scan wins.
module irq_hi_enc #(
  parameter int W = 256,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  bits,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = i[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/irq_slice_rd.sv
// Registered readback of one SLICE_W-bit window from each tracked vector.
module irq_slice_rd
  import irq_arb_pkg::*;
#(
  parameter int NVEC    = 256,
  parameter int SLICE_W = 32,
  localparam int NSLICE = NVEC / SLICE_W,
  localparam int SEL_W  = $clog2(NSLICE),
  localparam int OFF_W  = $clog2(SLICE_W)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [SEL_W-1:0]                   sel,
  input  logic [NUM_REGS-1:0][NVEC-1:0]      regs,
  output logic [NUM_REGS-1:0][SLICE_W-1:0]   slices
);
  logic [SEL_W+OFF_W-1:0] base;
  assign base = {sel, {OFF_W{1'b0}}};

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) slices[g] <= '0;
      else     slices[g] <= regs[g][base +: SLICE_W];
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int SLICE_W = 32,
  parameter int DATA_W  = 32,
  localparam int NVEC   = 1 << VEC_W,
  localparam int NSLICE = NVEC / SLICE_W,
  localparam int SEL_W  = $clog2(NSLICE)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dlv_valid,
  input  logic [VEC_W-1:0]   dlv_vec,
  input  logic               dlv_level,
  input  logic               ack_req,
  output logic               ack_done,
  output logic               ack_hit,
  output logic [VEC_W-1:0]   ack_vec,
  input  logic               eoi_wr,
  output logic               reoi_valid,
  output logic [VEC_W-1:0]   reoi_vec,
  input  logic               tpr_wr,
  input  logic [DATA_W-1:0]  tpr_wdata,
  output logic [VEC_W-1:0]   tpr_q,
  output logic               bad_vec,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [SLICE_W-1:0] pend_slice,
  output logic [SLICE_W-1:0] serv_slice,
  output logic [SLICE_W-1:0] trig_slice
);
  localparam logic [NVEC-1:0] ONE = {{(NVEC-1){1'b0}}, 1'b1};

  logic [NVEC-1:0] pend_q, serv_q, trig_q;

  // Delivery screening: class zero and the all-ones vector are refused.
  logic dlv_bad, dlv_take;
  logic [NVEC-1:0] dlv_oh, pend_mix;

  assign dlv_bad  = dlv_valid &&
                    ((dlv_vec[VEC_W-1 -: CLASS_W] == '0) || (&dlv_vec));
  assign dlv_take = dlv_valid && !dlv_bad && !pend_q[dlv_vec];
  assign dlv_oh   = ONE << dlv_vec;
  // Delivery is merged before the search so a same-cycle acknowledge sees it.
  assign pend_mix = dlv_take ? (pend_q | dlv_oh) : pend_q;

  logic             p_found, s_found;
  logic [VEC_W-1:0] p_idx, s_idx;

  irq_hi_enc #(.W(NVEC)) u_pend_enc (
    .bits (pend_mix),
    .found(p_found),
    .idx  (p_idx)
  );

  irq_hi_enc #(.W(NVEC)) u_serv_enc (
    .bits (serv_q),
    .found(s_found),
    .idx  (s_idx)
  );

  logic serv_ok, class_ok, grant, retire;
  logic [NVEC-1:0] grant_oh, retire_oh;

  assign serv_ok   = !s_found || (s_idx < p_idx);
  assign class_ok  = p_idx[VEC_W-1 -: CLASS_W] > tpr_q[VEC_W-1 -: CLASS_W];
  assign grant     = ack_req && p_found && serv_ok && class_ok;
  assign grant_oh  = grant ? (ONE << p_idx) : '0;
  assign retire    = eoi_wr && s_found;
  assign retire_oh = retire ? (ONE << s_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      serv_q <= '0;
      trig_q <= '0;
    end else begin
      pend_q <= pend_mix & ~grant_oh;
      serv_q <= (serv_q & ~retire_oh) | grant_oh;
      if (dlv_take) trig_q[dlv_vec] <= dlv_level;
    end
  end

  // Registered results.
  always_ff @(posedge clk) begin
    if (rst) begin
      ack_done   <= 1'b0;
      ack_hit    <= 1'b0;
      ack_vec    <= '0;
      reoi_valid <= 1'b0;
      reoi_vec   <= '0;
      bad_vec    <= 1'b0;
      tpr_q      <= '0;
    end else begin
      ack_done   <= ack_req;
      ack_hit    <= grant;
      ack_vec    <= grant ? p_idx : '0;
      reoi_valid <= retire && trig_q[s_idx];
      reoi_vec   <= (retire && trig_q[s_idx]) ? s_idx : '0;
      bad_vec    <= dlv_bad;
      if (tpr_wr) tpr_q <= tpr_wdata[VEC_W-1:0];
    end
  end

  logic tpr_hi_unused;
  assign tpr_hi_unused = ^tpr_wdata[DATA_W-1:VEC_W];

  logic [NUM_REGS-1:0][NVEC-1:0]    rd_bundle;
  logic [NUM_REGS-1:0][SLICE_W-1:0] rd_out;

  assign rd_bundle[REG_PEND] = pend_q;
  assign rd_bundle[REG_SERV] = serv_q;
  assign rd_bundle[REG_TRIG] = trig_q;

  irq_slice_rd #(.NVEC(NVEC), .SLICE_W(SLICE_W)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .sel   (rd_sel),
    .regs  (rd_bundle),
    .slices(rd_out)
  );

  assign pend_slice = rd_out[REG_PEND];
  assign serv_slice = rd_out[REG_SERV];
  assign trig_slice = rd_out[REG_TRIG];
endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk #(
  parameter int VEC_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              dlv_valid,
  input logic [VEC_W-1:0]  dlv_vec,
  input logic              ack_req,
  input logic              ack_done,
  input logic              ack_hit,
  input logic [VEC_W-1:0]  ack_vec,
  input logic              eoi_wr,
  input logic              reoi_valid,
  input logic              tpr_wr,
  input logic [DATA_W-1:0] tpr_wdata,
  input logic [VEC_W-1:0]  tpr_q,
  input logic              bad_vec
);
  // R5
  ack_done_chk: assert property (@(posedge clk) disable iff (rst)
    ack_req |=> ack_done);

  // R5
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_done && !ack_hit) |-> (ack_vec == '0));

  // R7
  tpr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ack_hit |-> (ack_vec[VEC_W-1 -: 4] > $past(tpr_q[VEC_W-1 -: 4])));

  // R8
  hit_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ack_hit |-> (ack_done && (ack_vec[VEC_W-1 -: 4] != '0) && !(&ack_vec)));

  // R4
  bad_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && ((dlv_vec[VEC_W-1 -: 4] == '0) || (&dlv_vec))) |=> bad_vec);

  // R9
  reoi_src_chk: assert property (@(posedge clk) disable iff (rst)
    reoi_valid |-> $past(eoi_wr));

  // R11
  tpr_load_chk: assert property (@(posedge clk) disable iff (rst)
    tpr_wr |=> (tpr_q == $past(tpr_wdata[VEC_W-1:0])));
endmodule

bind irq_prio_arb irq_prio_arb_chk #(.VEC_W(VEC_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_irq_prio_arb.sv
module tb_irq_prio_arb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        dlv_valid, dlv_level, ack_req, eoi_wr, tpr_wr;
  logic [7:0]  dlv_vec;
  logic [31:0] tpr_wdata;
  logic [2:0]  rd_sel;
  logic        ack_done, ack_hit, reoi_valid, bad_vec;
  logic [7:0]  ack_vec, reoi_vec, tpr_q;
  logic [31:0] pend_slice, serv_slice, trig_slice;

  int checks = 0;
  int errors = 0;

  irq_prio_arb dut (
    .clk(clk), .rst(rst),
    .dlv_valid(dlv_valid), .dlv_vec(dlv_vec), .dlv_level(dlv_level),
    .ack_req(ack_req), .ack_done(ack_done), .ack_hit(ack_hit), .ack_vec(ack_vec),
    .eoi_wr(eoi_wr), .reoi_valid(reoi_valid), .reoi_vec(reoi_vec),
    .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata), .tpr_q(tpr_q),
    .bad_vec(bad_vec), .rd_sel(rd_sel),
    .pend_slice(pend_slice), .serv_slice(serv_slice), .trig_slice(trig_slice)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference state built from the requirements.
  logic [255:0] m_pend, m_serv, m_trig;
  logic [7:0]   m_tpr;
  int           ack_q[$];   // {hit, vec}
  int           reoi_q[$];  // vec
  string        ack_tag_q[$];

  task automatic check(input bit ok, input string req, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int hi_bit(input logic [255:0] v);
    int r = -1;
    for (int i = 0; i < 256; i++) if (v[i]) r = i;
    return r;
  endfunction

  // Monitor: compare acknowledge and remote-notify results with the queues.
  always @(negedge clk) begin
    if (!rst && ack_done) begin
      if (ack_q.size() == 0) check(1'b0, "R5 unexpected ack_done", 1, 0);
      else begin
        int e;
        string t;
        e = ack_q.pop_front();
        t = ack_tag_q.pop_front();
        check({23'd0, ack_hit, ack_vec} == e, t, {ack_hit, ack_vec}, e);
      end
    end
    if (!rst && reoi_valid) begin
      if (reoi_q.size() == 0) check(1'b0, "R9/R10 unexpected reoi", reoi_vec, 0);
      else begin
        int e;
        e = reoi_q.pop_front();
        check(int'(reoi_vec) == e, "R9 reoi vector", reoi_vec, e);
      end
    end
  end

  // One clock of stimulus; the model follows the requirement ordering (R13).
  task automatic step(input bit dv, input int dvec, input bit dl, input bit ak,
                      input bit eo, input bit tw, input logic [31:0] twd,
                      input string tag);
    logic [255:0] s_old, t_old;
    bit exp_bad;
    int hp, hs;
    s_old = m_serv;
    t_old = m_trig;
    exp_bad = dv && (dvec < 16 || dvec == 255);
    if (dv && !exp_bad && !m_pend[dvec]) begin
      m_pend[dvec] = 1'b1;
      m_trig[dvec] = dl;
    end
    hs = hi_bit(s_old);
    if (ak) begin
      bit hit;
      hp  = hi_bit(m_pend);
      hit = (hp >= 0) && (hs < hp) && ((hp >> 4) > int'(m_tpr[7:4]));
      ack_q.push_back(hit ? (256 | hp) : 0);
      ack_tag_q.push_back(tag);
      if (hit) begin
        m_pend[hp] = 1'b0;
        m_serv[hp] = 1'b1;
      end
    end
    if (eo && hs >= 0) begin
      m_serv[hs] = 1'b0;
      if (t_old[hs]) reoi_q.push_back(hs);
    end
    if (tw) m_tpr = twd[7:0];
    dlv_valid = dv; dlv_vec = dvec[7:0]; dlv_level = dl;
    ack_req = ak; eoi_wr = eo; tpr_wr = tw; tpr_wdata = twd;
    @(negedge clk);
    check(bad_vec == exp_bad, "R4 bad_vec flag", bad_vec, exp_bad);
    dlv_valid = 0; ack_req = 0; eoi_wr = 0; tpr_wr = 0;
  endtask

  task automatic chk_slice(input int k, input string tag);
    rd_sel = k[2:0];
    @(negedge clk);
    check(pend_slice == m_pend[k*32 +: 32], {tag, " pending"}, pend_slice, m_pend[k*32 +: 32]);
    check(serv_slice == m_serv[k*32 +: 32], {tag, " service"}, serv_slice, m_serv[k*32 +: 32]);
    check(trig_slice == m_trig[k*32 +: 32], {tag, " trigger"}, trig_slice, m_trig[k*32 +: 32]);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    m_pend = '0; m_serv = '0; m_trig = '0; m_tpr = '0;
    rst = 1; dlv_valid = 0; dlv_vec = 0; dlv_level = 0; ack_req = 0;
    eoi_wr = 0; tpr_wr = 0; tpr_wdata = 0; rd_sel = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(ack_done == 0 && ack_hit == 0 && reoi_valid == 0 && bad_vec == 0,
          "R1 outputs idle", {ack_done, ack_hit, reoi_valid, bad_vec}, 0);
    check(tpr_q == 0, "R1 tpr", tpr_q, 0);
    for (int k = 0; k < 8; k++) chk_slice(k, "R1 empty slice");

    // R11 only the low byte is kept
    step(0, 0, 0, 0, 0, 1, 32'h1234_5620, "R11");
    check(tpr_q == 8'h20, "R11 tpr low byte", tpr_q, 8'h20);

    // R4 invalid vectors flagged, no state change
    step(1, 8'h05, 1, 0, 0, 0, 0, "R4");
    step(1, 8'hFF, 1, 0, 0, 0, 0, "R4");
    chk_slice(0, "R4 slice0");
    chk_slice(7, "R4 slice7");

    // R2 deliveries; R12 mapping
    step(1, 8'h31, 0, 0, 0, 0, 0, "R2");
    step(1, 8'h45, 1, 0, 0, 0, 0, "R2");
    step(1, 8'h2F, 0, 0, 0, 0, 0, "R2");
    chk_slice(1, "R2/R12 slice1");
    chk_slice(2, "R2/R12 slice2");
    // R3 duplicate delivery with edge kind dropped: trigger stays level
    step(1, 8'h45, 0, 0, 0, 0, 0, "R3");
    chk_slice(2, "R3 slice2");

    // R8 grant highest; R6 blocked by service; R9 level retire
    step(0, 0, 0, 1, 0, 0, 0, "R8 grant 0x45");
    step(0, 0, 0, 1, 0, 0, 0, "R6 service blocks");
    chk_slice(2, "R8 slice2");
    step(0, 0, 0, 0, 1, 0, 0, "R9 retire level");
    step(0, 0, 0, 1, 0, 0, 0, "R8 grant 0x31");
    step(0, 0, 0, 0, 1, 0, 0, "R9 retire edge");
    // R7 class of 0x2F equals tpr class 2
    step(0, 0, 0, 1, 0, 0, 0, "R7 tpr blocks");
    step(0, 0, 0, 0, 0, 1, 32'h0000_0010, "R11");
    step(0, 0, 0, 1, 0, 0, 0, "R7 grant 0x2F");
    step(0, 0, 0, 0, 1, 0, 0, "R9");
    // R10 empty end-of-interrupt
    step(0, 0, 0, 0, 1, 0, 0, "R10");
    for (int k = 0; k < 8; k++) chk_slice(k, "R10 slice");
    // R5 miss reports zero
    step(0, 0, 0, 1, 0, 0, 0, "R5 nothing waiting");

    // R13 delivery and acknowledge together
    step(1, 8'h90, 1, 1, 0, 0, 0, "R13 same-cycle grant");
    // R13 acknowledge against pre-retire service set
    step(1, 8'h60, 0, 0, 0, 0, 0, "R13");
    step(0, 0, 0, 1, 1, 0, 0, "R13 ack with eoi");
    step(0, 0, 0, 1, 0, 0, 0, "R8 grant 0x60");
    step(0, 0, 0, 0, 1, 0, 0, "R9");

    // R8 several vectors leave in descending order
    step(0, 0, 0, 0, 0, 1, 0, "R11");
    for (int j = 0; j < 6; j++) step(1, 8'h20 + 8'h25 * j, j[0], 0, 0, 0, 0, "R2");
    for (int k = 0; k < 8; k++) chk_slice(k, "R12 slice");
    for (int j = 0; j < 6; j++) begin
      step(0, 0, 0, 1, 0, 0, 0, "R8 descending");
      step(0, 0, 0, 0, 1, 0, 0, "R9 descending");
    end
    for (int k = 0; k < 8; k++) chk_slice(k, "R8 final slice");

    repeat (3) @(negedge clk);
    check(ack_q.size() == 0, "R5 missing ack_done", ack_q.size(), 0);
    check(reoi_q.size() == 0, "R9 missing reoi", reoi_q.size(), 0);
    finish_run();
  end
endmodule